// File: doc/BRIEF.md
# Prioritized Endpoint Interrupt Vector Generator

This block sits between the transfer-complete request lines of a USB device controller and the CPU's interrupt logic. It watches sixteen per-endpoint completion requests, each tagged as isochronous or not, plus one line that carries the general-purpose interrupt flags. From these it builds an 8-bit vector register that the CPU reads when it takes the interrupt. The CPU then uses the value as an offset into a table of 16-bit handler addresses.

The block has two modes, chosen by a mode input. In table mode, hardware fills in the low fields of the register from the highest-priority pending request. Software owns only the top two bits, which place the table on a 64-byte boundary. In bypass mode, the register is an ordinary software-written value that hardware leaves alone, so every interrupt goes to a single handler.

The register is an FPGA-style flop stage, so the value read reflects the requests and writes seen at the previous clock edge.

Top module: `ep_irq_vector`

## Requirements
- R1: Bit 0 of `vec_out` is always 0, in both modes.
- R2: While `rst` is held high at a clock edge, `vec_out` becomes 8'h00 and `irq_out` becomes 0.
- R3: In bypass mode (`sw_mode`=1), a write sets bits 7:1 of `vec_out` to `wr_data[7:1]`. Changes on `ep_req`, `ep_iso` or `gen_req` leave those bits unchanged.
- R4: In table mode (`sw_mode`=0), a write updates only the stored base field (`wr_data[7:6]` into bits 7:6). The stored bits 5:1 keep their earlier value, which shows in `vec_out[5:1]` once bypass mode is selected again.
- R5: In table mode, when any endpoint request is pending, `vec_out[5]` is 0 and `vec_out[4:1]` holds the binary number of the selected endpoint.
- R6: Among pending endpoint requests of the same kind, the lowest endpoint number is selected.
- R7: An endpoint whose request and isochronous bit are both set is selected ahead of every non-isochronous endpoint, whatever their numbers.
- R8: In table mode, with no endpoint request pending, `vec_out[5:1]` reads 5'b11111. This holds whether `gen_req` is high or low.
- R9: `irq_out` is 1 when any endpoint request or `gen_req` was high at the previous edge, and 0 otherwise.
- R10: `vec_out` and `irq_out` reflect the inputs and any write present at the previous rising clock edge: one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the vector register |
| wr_data | input | 8 | Write data for the vector register |
| sw_mode | input | 1 | 1 = bypass (software value), 0 = table index generation |
| ep_req | input | 16 | Per-endpoint completed-transfer requests |
| ep_iso | input | 16 | Per-endpoint isochronous attribute |
| gen_req | input | 1 | OR of the general interrupt flags (overrun/underrun, notifications) |
| vec_out | output | 8 | Vector register read value |
| irq_out | output | 1 | Registered interrupt request to the CPU |

## Verification
A wrong stored base or a wrong bypass value shows up in `vec_out[7:1]` on the cycle after the write. If bits 5:1 are lost during a table-mode write, the error stays hidden until the next switch to bypass mode, so the bench makes that switch on purpose. A fault in the priority encoder or the class arbiter gives a wrong endpoint number or class bit one cycle after the request pattern is applied. Random request patterns in both modes are compared every cycle against a priority model, so such faults appear within a few cycles.

// File: rtl/ep_irq_vector_pkg.sv
package ep_irq_vector_pkg;
  localparam int VEC_W    = 8;
  localparam int BASE_W   = 2;
  localparam int EPNUM_W  = 4;
  localparam int STORE_W  = VEC_W - 1;
  localparam logic [EPNUM_W-1:0] FLAG_EPNUM = '1;

  typedef struct packed {
    logic               ep_sel;
    logic [EPNUM_W-1:0] ep_num;
    logic               any;
  } arb_result_t;
endpackage

// File: rtl/ep_first_set.sv
module ep_first_set #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  // R6: the chosen line is set and no lower line is set
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    found |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));
  a_r6_none_found: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> !found);
endmodule

// File: rtl/ep_class_arb.sv
module ep_class_arb
  import ep_irq_vector_pkg::*;
#(
  parameter int NUM_EP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] ep_req,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic              gen_req,
  output arb_result_t       res
);
  localparam int IW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;

  logic [NUM_EP-1:0] iso_pend;
  logic              iso_found, any_found;
  logic [IW-1:0]     iso_idx, any_idx;

  assign iso_pend = ep_req & ep_iso;

  ep_first_set #(.N(NUM_EP), .IW(IW)) u_iso (
    .clk(clk), .rst(rst), .req(iso_pend), .found(iso_found), .idx(iso_idx));
  ep_first_set #(.N(NUM_EP), .IW(IW)) u_all (
    .clk(clk), .rst(rst), .req(ep_req), .found(any_found), .idx(any_idx));

  always_comb begin
    res.ep_sel = any_found;
    res.ep_num = FLAG_EPNUM;
    if (iso_found)      res.ep_num = EPNUM_W'(iso_idx);
    else if (any_found) res.ep_num = EPNUM_W'(any_idx);
    res.any = any_found | gen_req;
  end

  // R7: an isochronous pending endpoint always wins the class arbitration
  a_r7_iso_first: assert property (@(posedge clk) disable iff (rst)
    (iso_pend != '0) |-> (ep_iso[res.ep_num] && ep_req[res.ep_num]));
endmodule

// File: rtl/ep_vec_store.sv
module ep_vec_store
  import ep_irq_vector_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [VEC_W-1:0]   wr_data,
  input  logic               sw_mode,
  output logic [STORE_W-1:0] st_next
);
  logic [STORE_W-1:0] st_q;

  always_comb begin
    st_next = st_q;
    if (wr_en) begin
      if (sw_mode) st_next = wr_data[VEC_W-1:1];
      else         st_next = {wr_data[VEC_W-1 -: BASE_W], st_q[STORE_W-BASE_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_next;
  end

  // R3: stored value holds without a write
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(st_q));
  // R4: table-mode writes leave the low stored bits alone
  a_r4_base_only: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sw_mode) |=> (st_q[STORE_W-BASE_W-1:0] == $past(st_q[STORE_W-BASE_W-1:0])));
endmodule

// File: rtl/ep_irq_vector.sv
module ep_irq_vector
  import ep_irq_vector_pkg::*;
#(
  parameter int NUM_EP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              sw_mode,
  input  logic [NUM_EP-1:0] ep_req,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic              gen_req,
  output logic [7:0]        vec_out,
  output logic              irq_out
);
  arb_result_t        arb;
  logic [STORE_W-1:0] st_next;
  logic [VEC_W-1:0]   vec_d, vec_q;
  logic               irq_q;

  ep_class_arb #(.NUM_EP(NUM_EP)) u_arb (
    .clk(clk), .rst(rst), .ep_req(ep_req), .ep_iso(ep_iso),
    .gen_req(gen_req), .res(arb));

  ep_vec_store u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .sw_mode(sw_mode), .st_next(st_next));

  always_comb begin
    if (sw_mode)
      vec_d = {st_next, 1'b0};
    else
      vec_d = {st_next[STORE_W-1 -: BASE_W], ~arb.ep_sel, arb.ep_num, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      vec_q <= vec_d;
      irq_q <= arb.any;
    end
  end

  assign vec_out = vec_q;
  assign irq_out = irq_q;

  // R1: vectors are always word aligned
  a_r1_lsb_clear: assert property (@(posedge clk) disable iff (rst)
    vec_out[0] == 1'b0);
  // R5: endpoint class selected when any endpoint is pending
  a_r5_ep_class: assert property (@(posedge clk) disable iff (rst)
    (!sw_mode && (ep_req != '0)) |=> !vec_out[5]);
  // R8: shared flag vector when no endpoint is pending
  a_r8_flag_default: assert property (@(posedge clk) disable iff (rst)
    (!sw_mode && (ep_req == '0)) |=> (vec_out[5:1] == 5'h1F));
  // R9: request line follows pending sources
  a_r9_irq: assert property (@(posedge clk) disable iff (rst)
    ((ep_req != '0) || gen_req) |=> irq_out);
endmodule

// File: tb/sim_ep_irq_vector.sv
module sim_ep_irq_vector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        sw_mode = 1'b0;
  logic [15:0] ep_req = '0;
  logic [15:0] ep_iso = '0;
  logic        gen_req = 1'b0;
  logic [7:0]  vec_out;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] vec;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [6:0] mdl_st = '0;

  always #2 clk = ~clk;

  ep_irq_vector u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .sw_mode(sw_mode),
    .ep_req(ep_req), .ep_iso(ep_iso), .gen_req(gen_req),
    .vec_out(vec_out), .irq_out(irq_out));

  function automatic logic [4:0] mdl_low(input logic [15:0] r, input logic [15:0] iso);
    logic [15:0] p;
    p = r & iso;
    if (p == '0) p = r;
    for (int i = 0; i < 16; i++) if (p[i]) return {1'b0, 4'(i)};
    return 5'h1F;
  endfunction

  // driver: called at a falling edge, drives one cycle and queues the expectation
  task automatic drive(input bit we, input logic [7:0] d, input bit m,
                       input logic [15:0] r, input logic [15:0] iso,
                       input bit g, input string tag);
    exp_t e;
    wr_en = we; wr_data = d; sw_mode = m; ep_req = r; ep_iso = iso; gen_req = g;
    if (we) begin
      if (m) mdl_st = d[7:1];
      else   mdl_st = {d[7:6], mdl_st[4:0]};
    end
    if (m) e.vec = {mdl_st, 1'b0};
    else   e.vec = {mdl_st[6:5], mdl_low(r, iso), 1'b0};
    e.irq = (r != '0) || g;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor: samples just after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (vec_out !== e.vec || irq_out !== e.irq || vec_out[0] !== 1'b0) begin
        fails++;
        $display("FAIL %s: vec=%h irq=%b expected vec=%h irq=%b",
                 e.tag, vec_out, irq_out, e.vec, e.irq);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    checks++;
    if (vec_out !== 8'h00 || irq_out !== 1'b0) begin
      fails++;
      $display("FAIL R2: vec=%h irq=%b expected vec=00 irq=0", vec_out, irq_out);
    end
    rst = 1'b0;
    // R3, R1: bypass write, odd data keeps bit 0 clear
    drive(1, 8'hA7, 1, 16'h0000, 16'h0000, 0, "R3 bypass write");
    drive(0, 8'h00, 1, 16'h0F0F, 16'h00FF, 1, "R3 bypass ignores requests");
    drive(0, 8'h00, 1, 16'h8000, 16'h8000, 0, "R3 bypass ignores requests");
    // R4, R8: table-mode write touches base only
    drive(1, 8'h7F, 0, 16'h0000, 16'h0000, 0, "R8 idle default vector");
    drive(0, 8'h00, 1, 16'h0000, 16'h0000, 0, "R4 low bits kept after table write");
    drive(0, 8'h00, 0, 16'h0000, 16'h0000, 1, "R8 flag-only vector");
    // R5, R6
    drive(0, 8'h00, 0, 16'h0220, 16'h0000, 0, "R5 R6 endpoint 5 over 9");
    drive(0, 8'h00, 0, 16'h0001, 16'h0000, 1, "R6 endpoint 0 over flags");
    // R7
    drive(0, 8'h00, 0, 16'h8003, 16'h8000, 0, "R7 iso endpoint 15 first");
    drive(0, 8'h00, 0, 16'h3000, 16'h3000, 0, "R7 lowest iso endpoint");
    // R9, R10: one-cycle latency, request drop
    drive(0, 8'h00, 0, 16'h0000, 16'h0000, 0, "R9 R10 irq drops next cycle");
    // random patterns in both modes
    for (int k = 0; k < 600; k++) begin
      logic [15:0] r, iso;
      r   = 16'($urandom) & 16'($urandom);
      iso = 16'($urandom) & 16'($urandom);
      if (k % 7 == 0) r = '0;
      drive(($urandom % 9) == 0, 8'($urandom), ((k / 50) % 2) == 1, r, iso,
            ($urandom % 3) == 0, "R1 R6 R7 random");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule